// File: doc/BRIEF.md
# Shadow-Buffered Pulse-Width Modulator

This block is a single-channel pulse-width modulator driven from a small memory-mapped register interface. A free-running up-counter restarts from zero once it reaches the programmed period. The output is produced by comparing the counter with a duty (compare) value. A polarity control chooses whether the duty count sets the high time or the low time of each period.

Period and duty each have a working (active) copy and a staged (shadow) copy. Software that changes the waveform while it runs writes the staged pair. The staged values move into the working pair only at the end of the current period, so no period is ever cut short. When the modulator is stopped, software writes the working pair directly and the new values apply at once.

A control register switches the modulator output on, lets the counter run, picks the polarity, and masks an external restart input.

Top module: `apwm_shadow_top`

## Requirements
- R1: After reset, every register reads 0, the counter holds at 0 and `pwm_out` is low.
- R2: Byte offsets: working period 0x08, working duty 0x0C, staged period 0x10, staged duty 0x14, control 0x2A (16 bits, returned in rdata[15:0]). Any other offset reads 0. Control bit 4 = count enable, bit 9 = output enable, bit 10 = inverted polarity, bits 7:6 = 2'b11 masks the restart input.
- R3: With bit 4 set, the counter advances by one every clock. With bit 4 clear, the counter holds its value.
- R4: With bit 9 set and bit 10 clear, `pwm_out` is high exactly while counter < working duty, so a period of P and a duty of D give D high cycles in every P+1 cycles.
- R5: With bit 10 set, `pwm_out` is high exactly while counter >= working duty.
- R6: In normal polarity, a duty of 0 gives a constant low and a duty greater than the period gives a constant high.
- R7: A write to a staged register sets a pending flag. When the counter wraps with the flag set, both staged values are copied into the working pair and the flag clears. Before that wrap, the working pair is unchanged.
- R8: If a staged write lands in the same cycle as a wrap that copies, the copy takes the values held before that write, and the flag stays set for the next wrap.
- R9: A write to a working register takes effect in the next cycle, unless a copy from the staged pair happens in that same cycle, in which case the copy wins.
- R10: The counter wraps to 0 on the clock after it reaches or exceeds the working period. A period of 0 therefore gives a one-cycle period.
- R11: While counting with bits 7:6 not both set, `sync_in` high sends the counter to 0 on the next clock. With bits 7:6 = 2'b11, `sync_in` has no effect.
- R12: With bit 9 clear, `pwm_out` is low. With bits 9 and 4 both clear, the output is low and the counter is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid during a read strobe |
| sync_in | input | 1 | External counter restart |
| pwm_out | output | 1 | Modulated output |

## Verification
The waveform is tried with a mid-range duty, a zero duty, a duty above the period, and a zero period. High-cycle counts over one period separate a correct compare from an off-by-one error and show whether polarity inversion works. Staged updates are issued both well away from a wrap and on the exact wrap cycle. This separates immediate application from deferred application, and also shows which value wins when the two collide. The restart input is held with masking off and then with masking on, which shows whether the mask really blocks it.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    localparam int ADDR_W = 8;
    localparam int CTL_W  = 16;

    localparam logic [ADDR_W-1:0] OFS_PER_ACT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CMP_ACT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PER_SH  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CMP_SH  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CTL     = 8'h2A;

    localparam int CB_RUN    = 4;
    localparam int CB_SYNC_A = 6;
    localparam int CB_SYNC_B = 7;
    localparam int CB_PWM    = 9;
    localparam int CB_POL    = 10;

    typedef struct packed {
        logic pol;
        logic pwm;
        logic run;
        logic sync_off;
    } ctl_t;

    typedef struct packed {
        logic per_a;
        logic cmp_a;
        logic per_s;
        logic cmp_s;
        logic ctl;
    } wsel_t;

    function automatic ctl_t decode_ctl(logic [CTL_W-1:0] raw);
        ctl_t c;
        c.pol      = raw[CB_POL];
        c.pwm      = raw[CB_PWM];
        c.run      = raw[CB_RUN];
        c.sync_off = raw[CB_SYNC_A] & raw[CB_SYNC_B];
        return c;
    endfunction

    function automatic wsel_t decode_wr(logic en, logic we, logic [ADDR_W-1:0] a);
        wsel_t s;
        logic  w;
        w       = en & we;
        s.per_a = w && (a == OFS_PER_ACT);
        s.cmp_a = w && (a == OFS_CMP_ACT);
        s.per_s = w && (a == OFS_PER_SH);
        s.cmp_s = w && (a == OFS_CMP_SH);
        s.ctl   = w && (a == OFS_CTL);
        return s;
    endfunction

endpackage

// File: rtl/apwm_regfile.sv
module apwm_regfile
    import apwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wsel_t            wsel,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wrap,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0] per_sh,
    output logic [CNT_W-1:0] cmp_sh,
    output logic [CTL_W-1:0] ctl_raw
);

    logic pending_q;
    logic copy;
    logic sh_wr;

    assign copy  = wrap & pending_q;
    assign sh_wr = wsel.per_s | wsel.cmp_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_act   <= '0;
            cmp_act   <= '0;
            per_sh    <= '0;
            cmp_sh    <= '0;
            ctl_raw   <= '0;
            pending_q <= 1'b0;
        end else begin
            if (copy) begin
                per_act <= per_sh;
                cmp_act <= cmp_sh;
            end else begin
                if (wsel.per_a) per_act <= wdata;
                if (wsel.cmp_a) cmp_act <= wdata;
            end
            if (wsel.per_s) per_sh  <= wdata;
            if (wsel.cmp_s) cmp_sh  <= wdata;
            if (wsel.ctl)   ctl_raw <= wdata[CTL_W-1:0];
            if (sh_wr)
                pending_q <= 1'b1;
            else if (copy)
                pending_q <= 1'b0;
        end
    end

endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = run && (cnt >= period);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (run) begin
            if (wrap || restart)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/apwm_outgen.sv
module apwm_outgen
    import apwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  ctl_t             ctl,
    output logic             pwm_out
);

    logic below;

    always_comb begin
        below   = cnt < cmp;
        pwm_out = ctl.pwm & (below ^ ctl.pol);
    end

endmodule

// File: rtl/apwm_shadow_top.sv
module apwm_shadow_top
    import apwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              sync_in,
    output logic              pwm_out
);

    wsel_t            wsel;
    ctl_t             ctl;
    logic [CTL_W-1:0] ctl_raw;
    logic [CNT_W-1:0] per_act, cmp_act, per_sh, cmp_sh, cnt_q;
    logic             wrap;
    logic             restart;

    assign wsel    = decode_wr(bus_en, bus_we, bus_addr);
    assign ctl     = decode_ctl(ctl_raw);
    assign restart = sync_in & ~ctl.sync_off;

    apwm_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wsel(wsel), .wdata(bus_wdata), .wrap(wrap),
        .per_act(per_act), .cmp_act(cmp_act), .per_sh(per_sh), .cmp_sh(cmp_sh),
        .ctl_raw(ctl_raw)
    );

    apwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctl.run), .restart(restart),
        .period(per_act), .cnt(cnt_q), .wrap(wrap)
    );

    apwm_outgen #(.CNT_W(CNT_W)) u_out (
        .cnt(cnt_q), .cmp(cmp_act), .ctl(ctl), .pwm_out(pwm_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (bus_addr)
                OFS_PER_ACT: bus_rdata = per_act;
                OFS_CMP_ACT: bus_rdata = cmp_act;
                OFS_PER_SH:  bus_rdata = per_sh;
                OFS_CMP_SH:  bus_rdata = cmp_sh;
                OFS_CTL:     bus_rdata = CNT_W'(ctl_raw);
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/apwm_shadow_chk.sv
module apwm_shadow_chk
    import apwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              sync_in,
    input logic              pwm_out,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  per_act,
    input logic [CNT_W-1:0]  cmp_act,
    input ctl_t              ctl
);

    logic per_wr;
    assign per_wr = bus_en && bus_we && (bus_addr == OFS_PER_ACT);

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctl.run |=> $stable(cnt_q)); // R3

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && cnt_q < per_act && !sync_in) |=> cnt_q == $past(cnt_q) + 1'b1); // R3

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && cnt_q >= per_act) |=> cnt_q == '0); // R10

    AST_SYNC_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && ctl.sync_off && cnt_q < per_act) |=> cnt_q != '0); // R11

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pol && cmp_act == '0) |-> !pwm_out); // R6

    AST_PERIOD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!per_wr && !(ctl.run && cnt_q >= per_act)) |=> $stable(per_act)); // R7

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !ctl.pwm |-> !pwm_out); // R12

endmodule

bind apwm_shadow_top apwm_shadow_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .sync_in(sync_in), .pwm_out(pwm_out), .cnt_q(cnt_q), .per_act(per_act),
    .cmp_act(cmp_act), .ctl(ctl)
);

// File: tb/apwm_shadow_top_tb_top.sv
`timescale 1ns/1ps
module apwm_shadow_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sync_in = 1'b0;
    logic        pwm_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    apwm_shadow_top dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in), .pwm_out(pwm_out)
    );

    // behavioural reference state
    longint m_cnt, m_per, m_cmp, m_psh, m_csh;
    int     m_ctl;
    bit     m_pend;

    function automatic bit m_out();
        bit hi;
        if (((m_ctl >> 9) & 1) == 0) return 0;
        hi = (m_cnt < m_cmp);
        if ((m_ctl >> 10) & 1) hi = !hi;
        return hi;
    endfunction

    function automatic longint m_read(logic [7:0] a);
        case (a)
            8'h08: return m_per;
            8'h0C: return m_cmp;
            8'h10: return m_psh;
            8'h14: return m_csh;
            8'h2A: return m_ctl;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_per = 0; m_cmp = 0; m_psh = 0; m_csh = 0; m_ctl = 0; m_pend = 0;
        end else begin
            bit run, wrapped, copied, wr;
            longint old_psh, old_csh;
            run     = ((m_ctl >> 4) & 1) != 0;
            wrapped = run && (m_cnt >= m_per);
            copied  = wrapped && m_pend;
            old_psh = m_psh; old_csh = m_csh;
            wr      = bus_en && bus_we;
            if (run) begin
                if (wrapped || (sync_in && ((m_ctl >> 6) & 3) != 3)) m_cnt = 0;
                else m_cnt = m_cnt + 1;
            end
            if (copied) begin
                m_per = old_psh; m_cmp = old_csh; m_pend = 0;
            end else if (wr && bus_addr == 8'h08) m_per = bus_wdata;
            else if (wr && bus_addr == 8'h0C) m_cmp = bus_wdata;
            if (wr && bus_addr == 8'h10) begin m_psh = bus_wdata; m_pend = 1; end
            if (wr && bus_addr == 8'h14) begin m_csh = bus_wdata; m_pend = 1; end
            if (wr && bus_addr == 8'h2A) m_ctl = int'(bus_wdata[15:0]);
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference (R4, R5, R10, R11)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4/R5 waveform", pwm_out, m_out());
            if (bus_en && !bus_we) check("R2 readback", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        #1 bus_en = 0;
    endtask

    task automatic highs(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            h += int'(pwm_out);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int h;
        repeat (4) @(posedge clk);
        @(negedge clk); #1 rst = 0;

        // R1 reset state
        rd(8'h08, d); check("R1 per", d, 0);
        rd(8'h0C, d); check("R1 cmp", d, 0);
        rd(8'h10, d); check("R1 per_sh", d, 0);
        rd(8'h14, d); check("R1 cmp_sh", d, 0);
        rd(8'h2A, d); check("R1 ctl", d, 0);
        check("R1 out", pwm_out, 0);
        rd(8'h20, d); check("R2 unmapped", d, 0);

        // R9 direct writes while stopped
        wr(8'h08, 9); wr(8'h0C, 4);
        rd(8'h08, d); check("R9 per", d, 9);
        rd(8'h0C, d); check("R9 cmp", d, 4);

        // R2/R3/R4 run in normal polarity
        wr(8'h2A, 32'h2D0);
        rd(8'h2A, d); check("R2 ctl", d, 32'h2D0);
        repeat (5) @(negedge clk);
        highs(10, h); check("R4 high count", h, 4);

        // R5 inverted
        wr(8'h2A, 32'h6D0);
        repeat (3) @(negedge clk);
        highs(10, h); check("R5 high count", h, 6);
        wr(8'h2A, 32'h2D0);

        // R7 staged update
        wr(8'h10, 4); wr(8'h14, 2);
        rd(8'h10, d); check("R7 sh readback", d, 4);
        repeat (14) @(negedge clk);
        rd(8'h08, d); check("R7 per copied", d, 4);
        rd(8'h0C, d); check("R7 cmp copied", d, 2);
        highs(5, h); check("R7 high count", h, 2);

        // R6 corner duties
        wr(8'h14, 0);
        repeat (8) @(negedge clk);
        highs(5, h); check("R6 zero duty", h, 0);
        wr(8'h14, 7);
        repeat (8) @(negedge clk);
        highs(5, h); check("R6 duty above period", h, 5);

        // R10 zero period
        wr(8'h10, 0); wr(8'h14, 1);
        repeat (8) @(negedge clk);
        highs(5, h); check("R10 zero period", h, 5);
        wr(8'h08, 20); wr(8'h0C, 10);
        repeat (15) @(negedge clk);
        wr(8'h08, 2);
        repeat (4) @(negedge clk);
        highs(6, h); check("R10 lowered period", h, 6);

        // R11 restart input
        wr(8'h2A, 32'h210); wr(8'h08, 9); wr(8'h0C, 5);
        @(negedge clk); #1 sync_in = 1;
        @(negedge clk);
        highs(10, h); check("R11 sync restarts", h, 10);
        wr(8'h2A, 32'h2D0);
        @(negedge clk);
        highs(10, h); check("R11 sync masked", h, 5);
        #1 sync_in = 0;

        // R8 staged write on the wrap cycle
        wr(8'h08, 3); wr(8'h0C, 1);
        wr(8'h10, 6); wr(8'h14, 3);
        forever begin
            @(negedge clk);
            if (m_cnt >= m_per) break;
        end
        #1 bus_en = 1; bus_we = 1; bus_addr = 8'h10; bus_wdata = 8;
        @(negedge clk); #1 bus_en = 0; bus_we = 0;
        rd(8'h08, d); check("R8 old staged copied", d, 6);
        repeat (10) @(negedge clk);
        rd(8'h08, d); check("R8 pending kept", d, 8);

        // R12 stop
        wr(8'h2A, 32'h000);
        highs(10, h); check("R12 stopped low", h, 0);
        wr(8'h2A, 32'h2C0);
        @(negedge clk);
        highs(10, h); check("R3 frozen counter", h, 10 * int'(m_out()));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule